// File: doc/BRIEF.md
# Converter Serial Readout Port

This block is the device-side digital interface of an 18-bit sampling converter. It watches the convert strobe, the serial clock and the serial data input. At the start of every conversion it records two settings: which interface mode applies and whether a start (busy) bit is sent ahead of the data. When the converter core reports completion, the block takes the two's-complement result and shifts it out MSB first on the serial data output. The output enable stands in for a tri-state pad.

Two interface modes exist. In select mode the output is driven only while the convert line or the serial input is held low, which acts as a chip select. In chain mode the result register becomes a pass-through shift register, so several converters can share one data line. The pins CNV, SCK and SDI are oversampled in a fast system clock domain through two-stage synchronizers, so each SCK half-period must last at least four system clocks. The result and the done pulse already belong to that domain.

Top module: `adc_sout_port`

## Requirements
- R1: On a rising convert edge with no conversion running, the port enters chain mode if the serial input is low and select mode if it is high. The mode is reported on `stat_chain`, where 1 means chain.
- R2: In chain mode, the start bit is enabled (`stat_busy`=1) if the serial clock is high at the convert rising edge, and disabled if it is low.
- R3: In select mode, the start bit is enabled at conversion end if the convert line or the serial input is low at that moment, and disabled otherwise. `stat_busy` reads 0 from the convert edge until that point.
- R4: In select mode the output is undriven (`sdo_oe`=0) while a conversion runs, and at any time when neither the convert line nor the serial input is low.
- R5: In select mode without the start bit, the MSB appears as soon as the port is selected after completion. Each SCK falling edge advances one bit, and the output is released on the 18th falling edge.
- R6: In select mode, once the port has been selected during a readout, removing the select releases the output. The output stays released for that result even if the port is selected again.
- R7: In select mode with the start bit, the output is driven low when the conversion completes. The 1st to 18th falling edges then present D17 down to D0, and the 19th releases the output.
- R8: In chain mode the output is always driven. It is low while the conversion runs. After completion it shows D17, and on each SCK falling edge it shifts one place while the serial input level enters the bottom, so that level reaches the output 18 falling edges later.
- R9: In chain mode with the start bit, between completion and the first SCK falling edge the output copies the serial input, so it is high only when the upstream input is high. That first falling edge does not shift and exposes D17.
- R10: Whenever the convert line and the serial input are both low, the output is driven low, overriding any other state.
- R11: A convert rising edge during a running conversion changes neither the mode nor the conversion. A done pulse with no conversion running is ignored.
- R12: During reset the port is in select mode with the start bit off and the output undriven.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, oversamples the serial pins |
| rst_n | input | 1 | Synchronous active-low reset |
| cnv_in | input | 1 | Convert strobe pin (asynchronous) |
| sck_in | input | 1 | Serial clock pin (asynchronous) |
| sdi_in | input | 1 | Serial data / mode select pin (asynchronous) |
| conv_done | input | 1 | One-cycle pulse from the converter core at completion |
| result_in | input | DATA_W | Two's-complement conversion result, valid with conv_done |
| sdo | output | 1 | Serial data output level |
| sdo_oe | output | 1 | Output drive enable (0 means high impedance) |
| stat_chain | output | 1 | Latched mode: 1 chain, 0 select |
| stat_busy | output | 1 | Latched start-bit option |

## Verification
The bench builds the port with its default 18-bit result and two synchronizer stages. With those values it can check full frames bit by bit: 18 data bits after the select, 19 with the start bit, and a chain pass-through in which the serial input level comes back out after exactly 18 falling edges. Random results and random input streams run through every mode variant. The variants are the 3-wire and 4-wire select forms, an early release partway through a frame, and chain mode with and without the start bit. Directed steps cover the forced-low case, a convert edge during a conversion, and a stray done pulse.

// File: rtl/adc_sout_pkg.sv
// Shared definitions for the converter serial readout port.
// Assumes nothing beyond a default 18-bit result width.
package adc_sout_pkg;
    typedef enum logic {
        MODE_SELECT = 1'b0,
        MODE_CHAIN  = 1'b1
    } port_mode_e;

    localparam int DEF_DATA_W = 18;
endpackage

// File: rtl/adc_in_sync.sv
// Multi-stage synchronizer for a vector of asynchronous pins.
// Assumes each bit is an independent level; reset loads RST_VAL into every stage.
module adc_in_sync #(
    parameter int              N       = 3,
    parameter int              STAGES  = 2,
    parameter logic [N-1:0]    RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] d,
    output logic [N-1:0] q
);
    logic [STAGES-1:0][N-1:0] pipe;

    // Shift the pin levels through the synchronizer stages.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pipe <= {STAGES{RST_VAL}};
        end else begin
            pipe[0] <= d;
            for (int i = 1; i < STAGES; i++) begin
                pipe[i] <= pipe[i-1];
            end
        end
    end

    assign q = pipe[STAGES-1];
endmodule

// File: rtl/adc_edge_pick.sv
// Single-edge detector on a synchronized level; RISING picks the polarity.
// Assumes the input is already synchronous to clk.
module adc_edge_pick #(
    parameter bit   RISING  = 1'b1,
    parameter logic RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic lvl,
    output logic pulse
);
    logic prev;

    // Remember the level of the previous cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) prev <= RST_VAL;
        else        prev <= lvl;
    end

    generate
        if (RISING) begin : g_rise
            assign pulse = lvl & ~prev;
        end else begin : g_fall
            assign pulse = ~lvl & prev;
        end
    endgenerate
endmodule

// File: rtl/adc_cfg_latch.sv
// Latches the interface mode and the start-bit option, and tracks whether
// a conversion is running. Assumes conv_done is a one-cycle pulse.
module adc_cfg_latch
    import adc_sout_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic cnv_rise,
    input  logic cnv_s,
    input  logic sdi_s,
    input  logic sck_s,
    input  logic conv_done,
    output logic chain,
    output logic busy,
    output logic converting,
    output logic start,
    output logic load,
    output logic load_busy
);
    port_mode_e mode;

    assign chain     = (mode == MODE_CHAIN);
    assign start     = cnv_rise & ~converting;
    assign load      = conv_done & converting;
    assign load_busy = chain ? busy : (~cnv_s | ~sdi_s);

    // Capture the mode at conversion start and the start-bit option.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode       <= MODE_SELECT;
            busy       <= 1'b0;
            converting <= 1'b0;
        end else if (start) begin
            mode       <= sdi_s ? MODE_SELECT : MODE_CHAIN;
            busy       <= ~sdi_s & sck_s;
            converting <= 1'b1;
        end else if (load) begin
            converting <= 1'b0;
            if (!chain) busy <= ~cnv_s | ~sdi_s;
        end
    end

    // R11: the mode cannot move while a conversion runs
    a_r11_cfg_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        converting |=> (chain == $past(chain)));
    // R1: mode follows the serial input at the accepted convert edge
    a_r1_mode_pick: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (chain == !$past(sdi_s)));
    // R2: chain start-bit option follows the serial clock level
    a_r2_chain_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !sdi_s) |=> (busy == $past(sck_s)));
    // R3: select start-bit option follows the select at completion
    a_r3_select_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (load && !chain) |=> (busy == ($past(!cnv_s) || $past(!sdi_s))));
endmodule

// File: rtl/adc_out_shift.sv
// Result shift register serving both modes. In select mode it holds a frame of
// 18 or 19 bits (a start bit in the top slot) and counts falling edges. In
// chain mode its upper 18 bits form a pass-through register fed by the serial
// input. Assumes one sck_fall pulse per serial clock falling edge.
module adc_out_shift #(
    parameter int W = 18
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         chain,
    input  logic         converting,
    input  logic         start,
    input  logic         load,
    input  logic         load_busy,
    input  logic [W-1:0] result,
    input  logic         sck_fall,
    input  logic         cnv_s,
    input  logic         sdi_s,
    output logic         sdo_bit,
    output logic         oe_bit
);
    localparam int CW = $clog2(W + 2);
    localparam logic [CW-1:0] LEN_PLAIN = CW'(W);
    localparam logic [CW-1:0] LEN_BUSY  = CW'(W + 1);

    logic [W:0]    sreg;
    logic [CW-1:0] cnt;
    logic [CW-1:0] len;
    logic [CW-1:0] next_cnt;
    logic          active;
    logic          opened;
    logic          hold;
    logic          sel;
    logic          with_start;

    assign sel        = ~cnv_s | ~sdi_s;
    assign next_cnt   = cnt + 1'b1;
    assign with_start = load_busy & ~chain;

    // Load, shift and release the result according to the latched mode.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sreg   <= '0;
            cnt    <= '0;
            len    <= LEN_PLAIN;
            active <= 1'b0;
            opened <= 1'b0;
            hold   <= 1'b0;
        end else if (start) begin
            active <= 1'b0;
            opened <= 1'b0;
            hold   <= 1'b0;
            cnt    <= '0;
        end else if (load) begin
            sreg   <= with_start ? {1'b0, result} : {result, 1'b0};
            len    <= with_start ? LEN_BUSY : LEN_PLAIN;
            cnt    <= '0;
            active <= 1'b1;
            opened <= 1'b0;
            hold   <= chain & load_busy;
        end else if (active && chain) begin
            if (sck_fall) begin
                if (hold) hold <= 1'b0;
                else      sreg[W:1] <= {sreg[W-1:1], sdi_s};
            end
        end else if (active) begin
            if (sel) begin
                opened <= 1'b1;
                if (sck_fall) begin
                    sreg <= {sreg[W-1:0], 1'b0};
                    cnt  <= next_cnt;
                    if (next_cnt == len) active <= 1'b0;
                end
            end else if (opened) begin
                active <= 1'b0;
            end
        end
    end

    // Select the output level and drive enable for the current mode.
    always_comb begin
        if (chain) begin
            oe_bit = 1'b1;
            if (converting) sdo_bit = 1'b0;
            else if (hold)  sdo_bit = sdi_s;
            else            sdo_bit = sreg[W];
        end else begin
            oe_bit  = active & sel;
            sdo_bit = sreg[W];
        end
    end

    // R7: a frame with a start bit begins with a low level
    a_r7_start_low: assert property (@(posedge clk) disable iff (!rst_n)
        (load && with_start) |=> (active && !sdo_bit));
    // R6: losing the select after it was seen ends the readout
    a_r6_release: assert property (@(posedge clk) disable iff (!rst_n)
        (active && !chain && opened && !sel && !start && !load) |=> !active);
    // R5: the edge count never reaches the frame length while active
    a_r5_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
        (active && !chain) |-> (cnt < len));
    // R9: the first falling edge after completion does not shift
    a_r9_no_shift: assert property (@(posedge clk) disable iff (!rst_n)
        (active && chain && hold && sck_fall) |=> $stable(sreg));
endmodule

// File: rtl/adc_sout_port.sv
// Top of the converter serial readout port. Synchronizes the pins, finds the
// convert rising edge and the serial clock falling edge, and merges the
// forced-low rule over the mode output. Assumes each SCK half-period lasts at
// least four clk cycles and that result_in is valid with conv_done.
module adc_sout_port
    import adc_sout_pkg::*;
#(
    parameter int DATA_W      = DEF_DATA_W,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cnv_in,
    input  logic              sck_in,
    input  logic              sdi_in,
    input  logic              conv_done,
    input  logic [DATA_W-1:0] result_in,
    output logic              sdo,
    output logic              sdo_oe,
    output logic              stat_chain,
    output logic              stat_busy
);
    localparam int NPIN = 3;
    localparam logic [NPIN-1:0] PIN_IDLE = 3'b100;

    logic [NPIN-1:0] pins_s;
    logic cnv_s, sck_s, sdi_s;
    logic cnv_rise, sck_fall;
    logic chain, busy, converting, start, load, load_busy;
    logic sdo_bit, oe_bit, force_low;

    adc_in_sync #(.N(NPIN), .STAGES(SYNC_STAGES), .RST_VAL(PIN_IDLE)) u_sync (
        .clk(clk), .rst_n(rst_n), .d({sdi_in, sck_in, cnv_in}), .q(pins_s)
    );

    assign cnv_s = pins_s[0];
    assign sck_s = pins_s[1];
    assign sdi_s = pins_s[2];

    adc_edge_pick #(.RISING(1'b1), .RST_VAL(1'b0)) u_cnv_edge (
        .clk(clk), .rst_n(rst_n), .lvl(cnv_s), .pulse(cnv_rise)
    );

    adc_edge_pick #(.RISING(1'b0), .RST_VAL(1'b0)) u_sck_edge (
        .clk(clk), .rst_n(rst_n), .lvl(sck_s), .pulse(sck_fall)
    );

    adc_cfg_latch u_cfg (
        .clk(clk), .rst_n(rst_n), .cnv_rise(cnv_rise), .cnv_s(cnv_s),
        .sdi_s(sdi_s), .sck_s(sck_s), .conv_done(conv_done), .chain(chain),
        .busy(busy), .converting(converting), .start(start), .load(load),
        .load_busy(load_busy)
    );

    adc_out_shift #(.W(DATA_W)) u_shift (
        .clk(clk), .rst_n(rst_n), .chain(chain), .converting(converting),
        .start(start), .load(load), .load_busy(load_busy), .result(result_in),
        .sck_fall(sck_fall), .cnv_s(cnv_s), .sdi_s(sdi_s),
        .sdo_bit(sdo_bit), .oe_bit(oe_bit)
    );

    // Both select lines low forces a driven low level.
    assign force_low  = ~cnv_s & ~sdi_s;
    assign sdo        = force_low ? 1'b0 : sdo_bit;
    assign sdo_oe     = force_low | oe_bit;
    assign stat_chain = chain;
    assign stat_busy  = busy;

    // R4: select mode keeps the output undriven through a conversion
    a_r4_quiet_conv: assert property (@(posedge clk) disable iff (!rst_n)
        (!chain && converting && !force_low) |-> !sdo_oe);
    // R8: chain mode always drives the output
    a_r8_chain_drive: assert property (@(posedge clk) disable iff (!rst_n)
        chain |-> sdo_oe);
endmodule

// File: tb/adc_sout_port_bench.sv
module adc_sout_port_bench;
    localparam int CLK_P = 10;
    localparam int W     = 18;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cnv = 1'b0, sck = 1'b0, sdi = 1'b1, done = 1'b0;
    logic [W-1:0] res = '0;
    logic sdo, sdo_oe, stat_chain, stat_busy;
    int checks = 0;
    int fails = 0;

    always #(CLK_P/2) clk = ~clk;

    adc_sout_port #(.DATA_W(W), .SYNC_STAGES(2)) u_adc_sout_port (
        .clk(clk), .rst_n(rst_n), .cnv_in(cnv), .sck_in(sck), .sdi_in(sdi),
        .conv_done(done), .result_in(res), .sdo(sdo), .sdo_oe(sdo_oe),
        .stat_chain(stat_chain), .stat_busy(stat_busy)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic frame_bit(input logic [W-1:0] r, input int i, input bit with_start);
        if (with_start) return (i == 0) ? 1'b0 : r[W-i];
        return r[W-1-i];
    endfunction

    task automatic set_in(input logic c, input logic k, input logic s);
        @(negedge clk);
        cnv = c; sck = k; sdi = s;
        repeat (6) @(negedge clk);
    endtask

    task automatic fall_edge();
        set_in(cnv, 1'b1, sdi);
        set_in(cnv, 1'b0, sdi);
    endtask

    task automatic done_pulse(input logic [W-1:0] r);
        @(negedge clk);
        res = r; done = 1'b1;
        @(negedge clk);
        done = 1'b0;
        repeat (5) @(negedge clk);
    endtask

    // Select mode, 3-wire form, no start bit (R5)
    task automatic run_sel_plain(input logic [W-1:0] r);
        set_in(1'b0, 1'b0, 1'b1);
        set_in(1'b1, 1'b0, 1'b1);
        chk("R1 select mode", stat_chain, 0);
        chk("R4 undriven in conversion", sdo_oe, 0);
        done_pulse(r);
        chk("R3 no start bit", stat_busy, 0);
        chk("R4 undriven unselected", sdo_oe, 0);
        set_in(1'b0, 1'b0, 1'b1);
        chk("R5 driven on select", sdo_oe, 1);
        chk("R5 frame bit 0", sdo, frame_bit(r, 0, 1'b0));
        for (int i = 1; i < W; i++) begin
            fall_edge();
            chk("R5 frame bit", sdo, frame_bit(r, i, 1'b0));
        end
        fall_edge();
        chk("R5 release after 18th edge", sdo_oe, 0);
    endtask

    // Select mode with start bit, 3-wire (cnv) or 4-wire (sdi) select (R7, R6)
    task automatic run_sel_start(input logic [W-1:0] r, input bit four_wire, input int cut);
        set_in(1'b0, 1'b0, 1'b1);
        set_in(1'b1, 1'b0, 1'b1);
        if (four_wire) set_in(1'b1, 1'b0, 1'b0);
        else           set_in(1'b0, 1'b0, 1'b1);
        chk("R4 undriven in conversion", sdo_oe, 0);
        done_pulse(r);
        chk("R3 start bit on", stat_busy, 1);
        chk("R7 start bit driven", sdo_oe, 1);
        chk("R7 start bit low", sdo, 0);
        for (int i = 1; i <= W; i++) begin
            if (i == cut) begin
                set_in(1'b1, 1'b0, 1'b1);
                chk("R6 release on deselect", sdo_oe, 0);
                set_in(1'b1, 1'b0, 1'b0);
                chk("R6 stays released", sdo_oe, 0);
                set_in(1'b1, 1'b0, 1'b1);
                return;
            end
            fall_edge();
            chk("R7 frame bit", sdo, frame_bit(r, i, 1'b1));
            chk("R7 still driven", sdo_oe, 1);
        end
        fall_edge();
        chk("R7 release after 19th edge", sdo_oe, 0);
        set_in(1'b1, 1'b0, 1'b1);
    endtask

    // Chain mode, with or without start bit (R8, R9, R10, R11)
    task automatic run_chain(input logic [W-1:0] r, input bit with_start);
        logic [W-1:0] mdl;
        set_in(1'b0, with_start, 1'b0);
        chk("R10 forced low enable", sdo_oe, 1);
        chk("R10 forced low level", sdo, 0);
        set_in(1'b1, with_start, 1'b0);
        chk("R1 chain mode", stat_chain, 1);
        chk("R2 start bit option", stat_busy, with_start);
        set_in(1'b1, 1'b0, 1'b0);
        chk("R8 low during conversion", sdo, 0);
        chk("R8 driven during conversion", sdo_oe, 1);
        if (!with_start) begin
            set_in(1'b0, 1'b0, 1'b1);
            set_in(1'b1, 1'b0, 1'b1);
            chk("R11 mode kept", stat_chain, 1);
            set_in(1'b1, 1'b0, 1'b0);
        end
        done_pulse(r);
        mdl = r;
        if (with_start) begin
            chk("R9 follows low input", sdo, 0);
            set_in(1'b1, 1'b0, 1'b1);
            chk("R9 follows high input", sdo, 1);
            set_in(1'b1, 1'b0, 1'b0);
            fall_edge();
        end
        for (int n = 0; n < W + 6; n++) begin
            logic b;
            chk("R8 chain output bit", sdo, mdl[W-1]);
            chk("R8 chain driven", sdo_oe, 1);
            b = 1'($urandom % 2);
            set_in(1'b1, 1'b0, b);
            fall_edge();
            mdl = {mdl[W-2:0], b};
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        repeat (4) @(negedge clk);
        chk("R12 reset undriven", sdo_oe, 0);
        chk("R12 reset select mode", stat_chain, 0);
        chk("R12 reset start bit off", stat_busy, 0);
        @(negedge clk);
        rst_n = 1'b1;
        set_in(1'b0, 1'b0, 1'b1);
        done_pulse(18'h2AAAA);
        chk("R11 stray done ignored", sdo_oe, 0);
        for (int it = 0; it < 12; it++) begin
            int kind;
            logic [W-1:0] r;
            kind = (it < 5) ? it : int'($urandom % 5);
            r = W'($urandom);
            case (kind)
                0: run_sel_plain(r);
                1: run_sel_start(r, 1'b0, 0);
                2: run_sel_start(r, 1'b1, (it < 5) ? 0 : 2 + int'($urandom % 12));
                3: run_chain(r, 1'b0);
                default: run_chain(r, 1'b1);
            endcase
        end
        run_sel_plain(18'h20000);
        run_sel_start(18'h1FFFF, 1'b1, 5);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule